// File: doc/BRIEF.md
# Message-Line Signal-on-Write Controller

This block sits in a cache controller beside the data path and watches every write. Each write arrives with its word address and with the directory entry of the line it targets. The entry holds a 3-bit mode, a global flag and one target bit per processor. In a signalling message line, the processor bits name the processors to notify. Any write that lands on the final word of such a line arms the block.

When the data path reports that the armed write has completed, the block raises two requests. One is a signal transaction on the local bus. It carries the line address and the processor select mask. The other is a forwarding request to the next lower cache level, raised when the global flag is set. Each request is held under its own valid/ready handshake. New writes are stalled from the moment the armed write is accepted until every request it raised has been taken.

Page-granular notification uses the same rule. Software marks only the last line of a page as signalling and the other lines as quiet message lines.

Top module: `msgsig_ctrl`

## Requirements
- R1: After reset, `wr_ready_o` is 1 and both `sig_valid_o` and `fwd_valid_o` are 0.
- R2: A write accepted with mode 3'b101 and word offset LINE_WORDS-1 (the low log2(LINE_WORDS) address bits all 1) is armed. Its requests appear in the cycle after `wr_done_i` is sampled high, and never before.
- R3: Other writes raise no request and do not stall. This covers every other mode code (000 invalid, 001 shared, 010 private, 100 quiet message, and the unused 011, 110, 111) and every other offset.
- R4: `fwd_valid_o` is raised for an armed write only when its global flag was 1. `fwd_line_o` then equals the write address shifted right by log2(LINE_WORDS).
- R5: `sig_valid_o` is raised for an armed write only when its processor mask is non-zero. It then carries that mask and the line address. An armed write with a zero mask and a clear global flag raises nothing and does not stall.
- R6: While a request is valid and its ready is low, it stays valid with unchanged payload.
- R7: `wr_ready_o` is 0 from the cycle after an armed write is accepted until both request channels are empty.
- R8: The local and forwarding channels retire independently, each on its own ready.
- R9: `wr_done_i` has no effect when no armed write is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| wr_valid_i | input | 1 | write presented |
| wr_ready_o | output | 1 | write may be accepted |
| wr_addr_i | input | ADDR_W | word address of the write |
| dir_mode_i | input | 3 | directory mode of the target line |
| dir_global_i | input | 1 | directory global flag |
| dir_pmask_i | input | NPROC | directory processor bits |
| wr_done_i | input | 1 | data path reports the armed write complete |
| sig_valid_o | output | 1 | local signal transaction request |
| sig_ready_i | input | 1 | local bus takes the request |
| sig_line_o | output | ADDR_W-log2(LINE_WORDS) | line address of the signal |
| sig_pmask_o | output | NPROC | processor select mask |
| fwd_valid_o | output | 1 | forward request to the lower level |
| fwd_ready_i | input | 1 | lower level takes the request |
| fwd_line_o | output | ADDR_W-log2(LINE_WORDS) | line address forwarded |

## Verification
The bench builds the block with its defaults: 16-bit addresses, four words per line and four processors. That small shape lets one sweep cover all eight mode codes, every word offset, both global flag values, and both zero and non-zero masks. The sweep therefore reaches every arming and non-arming combination. Each armed case also holds both readies low for a cycle and then releases the channels one at a time. This exercises the payload hold, the stall window and independent retirement.

// File: rtl/msgsig_pkg.sv
package msgsig_pkg;
  typedef enum logic [2:0] {
    MODE_INV       = 3'b000,
    MODE_SHR       = 3'b001,
    MODE_PRV       = 3'b010,
    MODE_MSG_QUIET = 3'b100,
    MODE_MSG_SIG   = 3'b101
  } dir_mode_e;

  typedef enum logic {MON_IDLE, MON_WAIT} mon_state_e;
endpackage

// File: rtl/msgsig_decode.sv
module msgsig_decode
  import msgsig_pkg::*;
#(
  parameter int OFF_W = 2,
  parameter int NPROC = 4
) (
  input  logic [2:0]       mode_i,
  input  logic             global_i,
  input  logic [NPROC-1:0] pmask_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic             trig_o,
  output logic             loc_req_o,
  output logic             fwd_req_o
);
  logic is_sig, is_last;

  assign is_sig    = (mode_i == MODE_MSG_SIG);
  assign is_last   = &offset_i;
  assign loc_req_o = |pmask_i;
  assign fwd_req_o = global_i;
  // nothing to send means nothing to wait for
  assign trig_o    = is_sig & is_last & (loc_req_o | fwd_req_o);
endmodule

// File: rtl/msgsig_monitor.sv
module msgsig_monitor
  import msgsig_pkg::*;
#(
  parameter int LINE_W = 14,
  parameter int NPROC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              trig_i,
  input  logic              loc_req_i,
  input  logic              fwd_req_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [NPROC-1:0]  pmask_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              load_loc_o,
  output logic              load_fwd_o,
  output logic [LINE_W-1:0] line_o,
  output logic [NPROC-1:0]  pmask_o
);
  mon_state_e state_q;
  logic loc_q, fwd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_IDLE;
      loc_q   <= 1'b0;
      fwd_q   <= 1'b0;
      line_o  <= '0;
      pmask_o <= '0;
    end else begin
      case (state_q)
        MON_IDLE: if (acc_i && trig_i) begin
          state_q <= MON_WAIT;
          loc_q   <= loc_req_i;
          fwd_q   <= fwd_req_i;
          line_o  <= line_i;
          pmask_o <= pmask_i;
        end
        MON_WAIT: if (done_i) state_q <= MON_IDLE;
        default: state_q <= MON_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == MON_WAIT);
  assign load_loc_o = busy_o & done_i & loc_q;
  assign load_fwd_o = busy_o & done_i & fwd_q;
endmodule

// File: rtl/msgsig_chan.sv
module msgsig_chan #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/msgsig_ctrl.sv
module msgsig_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int NPROC      = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [2:0]        dir_mode_i,
  input  logic              dir_global_i,
  input  logic [NPROC-1:0]  dir_pmask_i,
  input  logic              wr_done_i,
  output logic              sig_valid_o,
  input  logic              sig_ready_i,
  output logic [LINE_W-1:0] sig_line_o,
  output logic [NPROC-1:0]  sig_pmask_o,
  output logic              fwd_valid_o,
  input  logic              fwd_ready_i,
  output logic [LINE_W-1:0] fwd_line_o
);
  logic trig, loc_req, fwd_req, acc, busy, load_loc, load_fwd;
  logic [LINE_W-1:0] cap_line;
  logic [NPROC-1:0]  cap_pmask;

  msgsig_decode #(.OFF_W(OFF_W), .NPROC(NPROC)) u_dec (
    .mode_i   (dir_mode_i),
    .global_i (dir_global_i),
    .pmask_i  (dir_pmask_i),
    .offset_i (wr_addr_i[OFF_W-1:0]),
    .trig_o   (trig),
    .loc_req_o(loc_req),
    .fwd_req_o(fwd_req)
  );

  assign wr_ready_o = ~busy & ~sig_valid_o & ~fwd_valid_o;
  assign acc        = wr_valid_i & wr_ready_o;

  msgsig_monitor #(.LINE_W(LINE_W), .NPROC(NPROC)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .trig_i    (trig),
    .loc_req_i (loc_req),
    .fwd_req_i (fwd_req),
    .line_i    (wr_addr_i[ADDR_W-1:OFF_W]),
    .pmask_i   (dir_pmask_i),
    .done_i    (wr_done_i),
    .busy_o    (busy),
    .load_loc_o(load_loc),
    .load_fwd_o(load_fwd),
    .line_o    (cap_line),
    .pmask_o   (cap_pmask)
  );

  msgsig_chan #(.W(NPROC + LINE_W)) u_loc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_loc),
    .data_i ({cap_pmask, cap_line}),
    .ready_i(sig_ready_i),
    .valid_o(sig_valid_o),
    .data_o ({sig_pmask_o, sig_line_o})
  );

  msgsig_chan #(.W(LINE_W)) u_fwd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_fwd),
    .data_i (cap_line),
    .ready_i(fwd_ready_i),
    .valid_o(fwd_valid_o),
    .data_o (fwd_line_o)
  );
endmodule

// File: rtl/msgsig_ctrl_chk.sv
module msgsig_ctrl_chk #(
  parameter int LINE_W = 14,
  parameter int NPROC  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_ready_o,
  input logic              wr_done_i,
  input logic              sig_valid_o,
  input logic              sig_ready_i,
  input logic [LINE_W-1:0] sig_line_o,
  input logic [NPROC-1:0]  sig_pmask_o,
  input logic              fwd_valid_o,
  input logic              fwd_ready_i,
  input logic [LINE_W-1:0] fwd_line_o
);
  assert_sig_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_valid_o && !sig_ready_i |=> sig_valid_o && $stable(sig_line_o) && $stable(sig_pmask_o));

  assert_fwd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o && !fwd_ready_i |=> fwd_valid_o && $stable(fwd_line_o));

  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_valid_o || fwd_valid_o) |-> !wr_ready_o);

  assert_mask_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_valid_o |-> (sig_pmask_o != '0));

  assert_after_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sig_valid_o) || $rose(fwd_valid_o)) |-> $past(wr_done_i));
endmodule

bind msgsig_ctrl msgsig_ctrl_chk #(.LINE_W(LINE_W), .NPROC(NPROC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_ready_o (wr_ready_o),
  .wr_done_i  (wr_done_i),
  .sig_valid_o(sig_valid_o),
  .sig_ready_i(sig_ready_i),
  .sig_line_o (sig_line_o),
  .sig_pmask_o(sig_pmask_o),
  .fwd_valid_o(fwd_valid_o),
  .fwd_ready_i(fwd_ready_i),
  .fwd_line_o (fwd_line_o)
);

// File: tb/sim_msgsig_ctrl.sv
module sim_msgsig_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid = 1'b0, wr_done = 1'b0, sig_ready = 1'b0, fwd_ready = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [2:0]  mode = '0;
  logic        glob = 1'b0;
  logic [3:0]  pmask = '0;
  logic        wr_ready, sig_valid, fwd_valid;
  logic [13:0] sig_line, fwd_line;
  logic [3:0]  sig_pmask;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  msgsig_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .dir_mode_i(mode), .dir_global_i(glob), .dir_pmask_i(pmask),
    .wr_done_i(wr_done), .sig_valid_o(sig_valid), .sig_ready_i(sig_ready),
    .sig_line_o(sig_line), .sig_pmask_o(sig_pmask), .fwd_valid_o(fwd_valid),
    .fwd_ready_i(fwd_ready), .fwd_line_o(fwd_line)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [2:0] m, input logic g,
                          input logic [3:0] pm);
    bit armed;
    armed = (m == 3'b101) && (a[1:0] == 2'b11) && (pm != 0 || g);
    @(negedge clk);
    chk(wr_ready == 1'b1, "R7 idle ready", int'(wr_ready), 1);
    wr_valid = 1'b1; wr_addr = a; mode = m; glob = g; pmask = pm;
    @(negedge clk);
    wr_valid = 1'b0;
    if (armed) begin
      chk(wr_ready == 1'b0, "R7 stall after arm", int'(wr_ready), 0);
      @(negedge clk);
      chk(!sig_valid && !fwd_valid, "R2 nothing before done", int'({sig_valid, fwd_valid}), 0);
      wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
      chk(sig_valid == (pm != 0), "R5 local valid", int'(sig_valid), int'(pm != 0));
      chk(fwd_valid == g, "R4 forward valid", int'(fwd_valid), int'(g));
      if (pm != 0) begin
        chk(sig_line == a[15:2], "R2 line", int'(sig_line), int'(a[15:2]));
        chk(sig_pmask == pm, "R2 mask", int'(sig_pmask), int'(pm));
      end
      if (g) chk(fwd_line == a[15:2], "R4 forward line", int'(fwd_line), int'(a[15:2]));
      @(negedge clk);
      chk(sig_valid == (pm != 0) && fwd_valid == g, "R6 hold", int'({sig_valid, fwd_valid}),
          int'({pm != 0, g}));
      if (pm != 0) chk(sig_pmask == pm && sig_line == a[15:2], "R6 payload", int'(sig_pmask), int'(pm));
      chk(wr_ready == 1'b0, "R7 stall while pending", int'(wr_ready), 0);
      sig_ready = 1'b1;
      @(negedge clk);
      sig_ready = 1'b0;
      chk(!sig_valid && fwd_valid == g, "R8 local retires alone", int'({sig_valid, fwd_valid}),
          int'({1'b0, g}));
      chk(wr_ready == !g, "R7 ready after local", int'(wr_ready), int'(!g));
      fwd_ready = 1'b1;
      @(negedge clk);
      fwd_ready = 1'b0;
      chk(!fwd_valid && wr_ready, "R8 forward retires", int'({fwd_valid, wr_ready}), 1);
    end else begin
      chk(wr_ready && !sig_valid && !fwd_valid, "R3 no signal no stall",
          int'({wr_ready, sig_valid, fwd_valid}), 4);
      wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
      @(negedge clk);
      chk(wr_ready && !sig_valid && !fwd_valid, "R9 stray done ignored",
          int'({wr_ready, sig_valid, fwd_valid}), 4);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_ready && !sig_valid && !fwd_valid, "R1 reset state",
        int'({wr_ready, sig_valid, fwd_valid}), 4);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(wr_ready && !sig_valid && !fwd_valid, "R1 after release",
        int'({wr_ready, sig_valid, fwd_valid}), 4);
    for (int m = 0; m < 8; m++)
      for (int off = 0; off < 4; off++)
        for (int g = 0; g < 2; g++)
          for (int k = 0; k < 2; k++) begin
            logic [3:0]  pm;
            logic [15:0] a;
            pm = (k == 0) ? 4'd0 : 4'((m * 3 + off * 5 + g) % 15 + 1);
            a  = 16'((m << 5) | (g << 9) | (k << 10) | ((m * 7 + off) << 11) | off);
            do_write(a, 3'(m), g[0], pm);
          end
    done_flag = 1;
  end

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule